// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

This block sits on the device side of an SDRAM interface. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines together with the clock-enable, bank-select, the 12-bit address and the data mask. It turns each sample into one command code. It keeps a table of which of the four banks hold an open row and which row that is. Each legal read or write is reported with its bank, column, the row open in that bank and its auto-precharge flag.

Address bit 10 means different things depending on the command. For a read or write it asks for auto precharge. For a precharge it selects all banks. The refresh encoding becomes an auto refresh or a self-refresh entry depending on the clock-enable. The data mask is presented twice: as a write mask with no added delay, and as a read output-disable two clocks later. Illegal sequences are not applied to the bank table. They raise a one-cycle protocol-error flag instead.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With cs_n high the command is inhibit (code 0) and the other strobes are ignored. With cs_n low and ras_n, cas_n, we_n all high the command is a no-operation (code 1).
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 011 is activate (code 2), 101 is read (3), 100 is write (4), 110 is burst stop (5), 010 is precharge (6), 001 with cke high is auto refresh (7), 001 with cke low is self-refresh entry (8), and 000 is mode load (9). Each code appears on cmd_o after the edge that samples it.
- R3: Activate to a closed bank sets bit ba of bank_open and records addr[11:0] as that bank's row.
- R4: Read or write to an open bank pulses acc_valid for one cycle. It reports acc_write (1 for write), acc_bank, acc_col = addr[8:0], acc_autopre = addr[10], and acc_row = the row open in that bank.
- R5: Precharge with addr[10] low closes only bank ba. Precharge with addr[10] high closes all four banks whatever ba is.
- R6: A read or write with addr[10] high closes its bank at the same edge that reports the access.
- R7: A read or write to a closed bank, or an activate to an open bank, sets proto_err for that cycle. It gives no acc_valid and leaves bank_open unchanged.
- R8: An auto refresh, self-refresh entry or mode load while any bank is open sets proto_err and has no other effect.
- R9: A mode load with every bank closed copies addr[11:0] into mode_reg.
- R10: After a legal self-refresh entry, self_ref stays high and every sample with cke low reports code 11 and is ignored. The first sample with cke high reports code 10 and clears self_ref.
- R11: wr_mask equals the dqm sampled with the current command. rd_hiz equals the dqm sampled two edges earlier.
- R12: Reset clears all banks to closed, mode_reg to 0, self_ref, acc_valid and proto_err to 0, cmd_o to code 0, and sets wr_mask and rd_hiz to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / op-code bus |
| dqm | input | 1 | Data mask |
| cmd_o | output | 4 | Decoded command code |
| acc_valid | output | 1 | Read or write accepted this cycle |
| acc_write | output | 1 | Access is a write |
| acc_bank | output | 2 | Bank of the access |
| acc_col | output | 9 | Column of the access |
| acc_row | output | 12 | Row open in the accessed bank |
| acc_autopre | output | 1 | Auto precharge requested |
| bank_open | output | 4 | Open flag per bank |
| mode_reg | output | 12 | Last legal mode op-code |
| self_ref | output | 1 | Self refresh in effect |
| proto_err | output | 1 | Illegal command sequence |
| wr_mask | output | 1 | Write data mask, no added delay |
| rd_hiz | output | 1 | Read output disable, two-clock delay |

## Verification
All decoded results, access reports, bank flags, error flags and wr_mask are due right after the rising edge that samples the command. rd_hiz is due two rising edges later. The bench changes inputs on the falling edge and steps one full clock per command. It compares every output on the following falling edge against a reference model that advances once per command. It keeps a three-entry history of the applied dqm values, so the read gate is compared against the value from two commands earlier.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    C_INH    = 4'd0,
    C_NOP    = 4'd1,
    C_ACT    = 4'd2,
    C_RD     = 4'd3,
    C_WR     = 4'd4,
    C_BST    = 4'd5,
    C_PRE    = 4'd6,
    C_AREF   = 4'd7,
    C_SREF   = 4'd8,
    C_LMR    = 4'd9,
    C_SRX    = 4'd10,
    C_SRHOLD = 4'd11
  } cmd_e;
endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic in_sr,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_INH;
    if (in_sr) begin
      cmd = cke ? C_SRX : C_SRHOLD;
    end else if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = cke ? C_AREF : C_SREF;
        default: cmd = C_LMR;
      endcase
    end
  end
endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks #(
  parameter int NB    = 4,
  parameter int ROW_W = 12,
  localparam int BA_W = $clog2(NB)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act_en,
  input  logic [BA_W-1:0]           act_bank,
  input  logic [ROW_W-1:0]          act_row,
  input  logic                      cls_en,
  input  logic [BA_W-1:0]           cls_bank,
  input  logic                      cls_all,
  output logic [NB-1:0]             open_o,
  output logic [NB-1:0][ROW_W-1:0]  row_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic open_d;
    logic row_en;

    always_comb begin
      row_en = act_en && (act_bank == BA_W'(b));
      open_d = open_o[b];
      if (row_en) begin
        open_d = 1'b1;
      end else if (cls_all || (cls_en && (cls_bank == BA_W'(b)))) begin
        open_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_o[b] <= 1'b0;
        row_o[b]  <= '0;
      end else begin
        open_o[b] <= open_d;
        if (row_en) row_o[b] <= act_row;
      end
    end
  end
endmodule

// File: rtl/sdram_trk_dqm.sv
module sdram_trk_dqm #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dqm,
  output logic wr_mask,
  output logic rd_hiz
);
  logic [RD_LAT:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= 1'b1;
    else        stage[0] <= dqm;
  end

  for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= 1'b1;
      else        stage[i] <= stage[i-1];
    end
  end

  assign wr_mask = stage[0];
  assign rd_hiz  = stage[RD_LAT];
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10,
  parameter int RD_LAT = 2,
  localparam int BA_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  output logic [3:0]        cmd_o,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [BA_W-1:0]   acc_bank,
  output logic [COL_W-1:0]  acc_col,
  output logic [ADDR_W-1:0] acc_row,
  output logic              acc_autopre,
  output logic [NB-1:0]     bank_open,
  output logic [ADDR_W-1:0] mode_reg,
  output logic              self_ref,
  output logic              proto_err,
  output logic              wr_mask,
  output logic              rd_hiz
);
  cmd_e                      cmd;
  logic [NB-1:0][ADDR_W-1:0] rows;
  logic                      act_en, cls_en, cls_all;
  logic [BA_W-1:0]           cls_bank;
  logic                      err_d, av_d, aw_d, ap_d, sr_d;
  logic [COL_W-1:0]          col_d;
  logic [ADDR_W-1:0]         row_d, mode_d;
  logic                      any_open, sel_open;

  sdram_trk_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .in_sr(self_ref), .cmd(cmd)
  );

  sdram_trk_banks #(.NB(NB), .ROW_W(ADDR_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(act_en), .act_bank(ba), .act_row(addr),
    .cls_en(cls_en), .cls_bank(cls_bank), .cls_all(cls_all),
    .open_o(bank_open), .row_o(rows)
  );

  sdram_trk_dqm #(.RD_LAT(RD_LAT)) u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm),
    .wr_mask(wr_mask), .rd_hiz(rd_hiz)
  );

  assign any_open = |bank_open;
  assign sel_open = bank_open[ba];

  // next-state
  always_comb begin
    err_d    = 1'b0;
    av_d     = 1'b0;
    aw_d     = 1'b0;
    ap_d     = 1'b0;
    col_d    = '0;
    row_d    = '0;
    act_en   = 1'b0;
    cls_en   = 1'b0;
    cls_all  = 1'b0;
    cls_bank = ba;
    mode_d   = mode_reg;
    sr_d     = self_ref;
    unique case (cmd)
      C_ACT: begin
        if (sel_open) err_d = 1'b1;
        else          act_en = 1'b1;
      end
      C_RD, C_WR: begin
        if (!sel_open) begin
          err_d = 1'b1;
        end else begin
          av_d   = 1'b1;
          aw_d   = (cmd == C_WR);
          ap_d   = addr[AP_BIT];
          col_d  = addr[COL_W-1:0];
          row_d  = rows[ba];
          cls_en = addr[AP_BIT];
        end
      end
      C_PRE: begin
        if (addr[AP_BIT]) cls_all = 1'b1;
        else              cls_en  = 1'b1;
      end
      C_AREF: err_d = any_open;
      C_SREF: begin
        if (any_open) err_d = 1'b1;
        else          sr_d  = 1'b1;
      end
      C_LMR: begin
        if (any_open) err_d  = 1'b1;
        else          mode_d = addr;
      end
      C_SRX:   sr_d = 1'b0;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o       <= C_INH;
      acc_valid   <= 1'b0;
      acc_write   <= 1'b0;
      acc_bank    <= '0;
      acc_col     <= '0;
      acc_row     <= '0;
      acc_autopre <= 1'b0;
      mode_reg    <= '0;
      self_ref    <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      cmd_o       <= cmd;
      acc_valid   <= av_d;
      acc_write   <= aw_d;
      acc_bank    <= av_d ? ba : '0;
      acc_col     <= col_d;
      acc_row     <= row_d;
      acc_autopre <= ap_d;
      mode_reg    <= mode_d;
      self_ref    <= sr_d;
      proto_err   <= err_d;
    end
  end
endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk #(
  parameter int NB     = 4,
  parameter int ADDR_W = 12,
  localparam int BA_W  = $clog2(NB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [BA_W-1:0]   ba,
  input logic [3:0]        cmd_o,
  input logic              acc_valid,
  input logic              acc_autopre,
  input logic [BA_W-1:0]   acc_bank,
  input logic [NB-1:0]     bank_open,
  input logic [ADDR_W-1:0] mode_reg,
  input logic              self_ref,
  input logic              proto_err,
  input logic              wr_mask,
  input logic              rd_hiz
);
  a_r7_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !proto_err);

  a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd2 && !proto_err) |-> bank_open[$past(ba)]);

  a_r4_plain_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_autopre) |-> bank_open[acc_bank]);

  a_r6_autopre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_autopre) |-> !bank_open[acc_bank]);

  a_r8_mode_kept_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $stable(mode_reg));

  a_r10_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && !cke) |=> self_ref);

  a_r10_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref && cke) |=> !self_ref);

  // Read gate trails the write mask by two edges (default read latency).
  a_r11_rd_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hiz == $past(wr_mask, 2));
endmodule

bind sdram_cmd_tracker sdram_trk_chk #(.NB(NB), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .ba(ba), .cmd_o(cmd_o),
  .acc_valid(acc_valid), .acc_autopre(acc_autopre), .acc_bank(acc_bank),
  .bank_open(bank_open), .mode_reg(mode_reg), .self_ref(self_ref),
  .proto_err(proto_err), .wr_mask(wr_mask), .rd_hiz(rd_hiz)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, cke, dqm;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmd_o;
  logic        acc_valid, acc_write, acc_autopre;
  logic [1:0]  acc_bank;
  logic [8:0]  acc_col;
  logic [11:0] acc_row;
  logic [3:0]  bank_open;
  logic [11:0] mode_reg;
  logic        self_ref, proto_err, wr_mask, rd_hiz;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [3:0]       m_open;
  logic [3:0][11:0] m_row;
  logic [11:0]      m_mode;
  logic             m_sr;
  logic             p0, p1, p2;
  logic [3:0]       e_cmd;
  logic             e_err, e_av, e_w;
  logic [11:0]      e_row;

  always #4 clk = ~clk;

  sdram_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .cmd_o(cmd_o), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_bank(acc_bank), .acc_col(acc_col), .acc_row(acc_row),
    .acc_autopre(acc_autopre), .bank_open(bank_open), .mode_reg(mode_reg),
    .self_ref(self_ref), .proto_err(proto_err), .wr_mask(wr_mask),
    .rd_hiz(rd_hiz)
  );

  function automatic void chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  task automatic model(logic cs, logic ra, logic ca, logic we, logic ck,
                       logic [1:0] b, logic [11:0] a);
    logic any;
    any   = |m_open;
    e_err = 1'b0;
    e_av  = 1'b0;
    e_w   = 1'b0;
    e_row = m_row[b];
    if (m_sr) begin
      if (ck) begin e_cmd = 4'd10; m_sr = 1'b0; end
      else e_cmd = 4'd11;
    end else if (cs) begin
      e_cmd = 4'd0;
    end else begin
      case ({ra, ca, we})
        3'b111: e_cmd = 4'd1;
        3'b011: begin
          e_cmd = 4'd2;
          if (m_open[b]) e_err = 1'b1;
          else begin m_open[b] = 1'b1; m_row[b] = a; end
        end
        3'b101, 3'b100: begin
          e_cmd = we ? 4'd3 : 4'd4;
          e_w   = !we;
          if (!m_open[b]) e_err = 1'b1;
          else begin e_av = 1'b1; if (a[10]) m_open[b] = 1'b0; end
        end
        3'b110: e_cmd = 4'd5;
        3'b010: begin
          e_cmd = 4'd6;
          if (a[10]) m_open = '0;
          else       m_open[b] = 1'b0;
        end
        3'b001: begin
          e_cmd = ck ? 4'd7 : 4'd8;
          if (any) e_err = 1'b1;
          else if (!ck) m_sr = 1'b1;
        end
        default: begin
          e_cmd = 4'd9;
          if (any) e_err = 1'b1;
          else m_mode = a;
        end
      endcase
    end
  endtask

  task automatic step(string req, logic cs, logic ra, logic ca, logic we, logic ck,
                      logic [1:0] b, logic [11:0] a, logic dq);
    cs_n = cs; ras_n = ra; cas_n = ca; we_n = we; cke = ck;
    ba = b; addr = a; dqm = dq;
    model(cs, ra, ca, we, ck, b, a);
    p2 = p1; p1 = p0; p0 = dq;
    @(posedge clk);
    @(negedge clk);
    chk(req, "cmd_o", 32'(cmd_o), 32'(e_cmd));
    chk(req, "proto_err", 32'(proto_err), 32'(e_err));
    chk(req, "acc_valid", 32'(acc_valid), 32'(e_av));
    if (e_av) begin
      chk(req, "acc_write", 32'(acc_write), 32'(e_w));
      chk(req, "acc_bank", 32'(acc_bank), 32'(b));
      chk(req, "acc_col", 32'(acc_col), 32'(a[8:0]));
      chk(req, "acc_autopre", 32'(acc_autopre), 32'(a[10]));
      chk(req, "acc_row", 32'(acc_row), 32'(e_row));
    end
    chk(req, "bank_open", 32'(bank_open), 32'(m_open));
    chk(req, "mode_reg", 32'(mode_reg), 32'(m_mode));
    chk(req, "self_ref", 32'(self_ref), 32'(m_sr));
    chk("R11", "wr_mask", 32'(wr_mask), 32'(p0));
    chk("R11", "rd_hiz", 32'(rd_hiz), 32'(p2));
  endtask

  // strobe patterns {ras,cas,we}
  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                         S_BST = 3'b110, S_PRE = 3'b010, S_REF = 3'b001,
                         S_LMR = 3'b000, S_NOP = 3'b111;

  task automatic go(string req, logic [2:0] s, logic ck, logic [1:0] b,
                    logic [11:0] a, logic dq);
    step(req, 1'b0, s[2], s[1], s[0], ck, b, a, dq);
  endtask

  initial begin
    #1600000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    cke = 1'b1; ba = '0; addr = '0; dqm = 1'b0;
    m_open = '0; m_row = '0; m_mode = '0; m_sr = 1'b0;
    p0 = 1'b1; p1 = 1'b1; p2 = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "cmd_o", 32'(cmd_o), 32'd0);
    chk("R12", "bank_open", 32'(bank_open), 32'd0);
    chk("R12", "mode_reg", 32'(mode_reg), 32'd0);
    chk("R12", "self_ref", 32'(self_ref), 32'd0);
    chk("R12", "acc_valid", 32'(acc_valid), 32'd0);
    chk("R12", "proto_err", 32'(proto_err), 32'd0);
    chk("R12", "wr_mask", 32'(wr_mask), 32'd1);
    chk("R12", "rd_hiz", 32'(rd_hiz), 32'd1);
    rst_n = 1'b1;

    // R1: inhibit with active-looking strobes, then a plain no-op
    step("R1", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 12'h123, 1'b0);
    go("R1", S_NOP, 1'b1, 2'd0, 12'h000, 1'b1);
    // R3 open bank 1
    go("R3", S_ACT, 1'b1, 2'd1, 12'hABC, 1'b0);
    // R4 read, upper bits above column set but A10 low
    go("R4", S_RD, 1'b1, 2'd1, 12'hBFF, 1'b1);
    go("R4", S_WR, 1'b1, 2'd1, 12'h055, 1'b0);
    // R6 write with auto precharge closes bank 1
    go("R6", S_WR, 1'b1, 2'd1, 12'h40F, 1'b1);
    // R7 read to closed bank; activate to open bank
    go("R7", S_RD, 1'b1, 2'd1, 12'h001, 1'b0);
    go("R7", S_ACT, 1'b1, 2'd2, 12'h777, 1'b0);
    go("R7", S_ACT, 1'b1, 2'd2, 12'h111, 1'b1);
    go("R3", S_ACT, 1'b1, 2'd3, 12'hFFF, 1'b0);
    // R8 refresh / mode load while open
    go("R8", S_LMR, 1'b1, 2'd0, 12'h3A3, 1'b1);
    go("R8", S_REF, 1'b1, 2'd0, 12'h000, 1'b0);
    go("R8", S_REF, 1'b0, 2'd0, 12'h000, 1'b0);
    // R5 single-bank precharge, then precharge-all with ba pointing at a closed bank
    go("R5", S_PRE, 1'b1, 2'd2, 12'h000, 1'b0);
    go("R5", S_PRE, 1'b1, 2'd0, 12'h400, 1'b1);
    // R2 burst stop, auto refresh when idle
    go("R2", S_BST, 1'b1, 2'd0, 12'h000, 1'b0);
    go("R2", S_REF, 1'b1, 2'd0, 12'h000, 1'b1);
    // R9 mode load when idle
    go("R9", S_LMR, 1'b1, 2'd0, 12'h5A5, 1'b0);
    // R10 self refresh: enter, ignored commands, exit
    go("R10", S_REF, 1'b0, 2'd0, 12'h000, 1'b1);
    go("R10", S_ACT, 1'b0, 2'd1, 12'h222, 1'b0);
    go("R10", S_LMR, 1'b0, 2'd0, 12'hFFF, 1'b1);
    step("R10", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 12'h000, 1'b1);
    go("R10", S_ACT, 1'b1, 2'd1, 12'h222, 1'b0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] s;
      logic ck;
      logic cs;
      int op;
      op = int'($urandom_range(0, 15));
      case (op)
        0, 1, 2:  s = S_ACT;
        3, 4, 5:  s = S_RD;
        6, 7, 8:  s = S_WR;
        9, 10:    s = S_PRE;
        11:       s = S_REF;
        12:       s = S_LMR;
        13:       s = S_BST;
        default:  s = S_NOP;
      endcase
      ck = ($urandom_range(0, 7) != 0);
      cs = ($urandom_range(0, 9) == 0);
      step("R2", cs, s[2], s[1], s[0], ck, 2'($urandom_range(0, 3)),
           12'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule